// File: doc/BRIEF.md
# Audio DAC Pop-Suppression Sequencer

This block owns the DAC code and the amplifier controls of an audio output path during power transitions. When asked to start, it waits until the external flash chip-select is driven low, so that the supply disturbance from that event lands before the output moves. It then walks the DAC code up one LSB per step from zero to mid-scale, which is half the supply. Next it loads the target volume, mutes the speaker, enables the amplifier, waits a settle time, and unmutes. Only then does it raise a ready flag, which hands the DAC over to the audio stream.

When asked to stop, the sequencer disables the amplifier and clears the volume. It then walks the code back down to zero one LSB per step. At the end it mutes and switches the DAC off. A step tick sets the pace of every ramp step and every settle unit. By default the tick divider gives about 10 µs per step at a 200 MHz clock. The settle time is given as a count of step ticks and is captured only while the block is off.

Top module: `pop_seq_top`

## Requirements
- R1: After reset: dac_code is 0, dac_en is 1, amp_en is 0, spk_mute_n is 1, vol_code is 0 and ready is 0.
- R2: During power-up, dac_code changes only by +1. It changes once every TICK_DIV clock cycles, from 0 up to MID = 2^(CODE_W-1), which is 0x8000 by default. It never exceeds MID.
- R3: After a start request, dac_code stays at 0 for as long as flash_cs_n is high. The ramp begins only after flash_cs_n has been sampled low.
- R4: In the cycle where dac_code first equals MID, vol_code already holds vol_target. spk_mute_n goes low in the next cycle, and amp_en goes high in the cycle after that. amp_en is never high unless dac_code equals MID.
- R5: spk_mute_n rises max(S,1)*TICK_DIV-1 cycles after amp_en rises. S is the settle_cfg value captured while the block was off. Changes to settle_cfg outside the off state have no effect.
- R6: ready is high only in the playing state. It rises together with spk_mute_n and falls together with amp_en. While ready is high, amp_en=1, spk_mute_n=1 and dac_code=MID.
- R7: One cycle after a stop request in the playing state, amp_en=0, vol_code=0 and ready=0. dac_code then falls by 1 every TICK_DIV cycles from MID to 0. spk_mute_n stays high throughout this ramp.
- R8: One cycle after dac_code reaches 0 on the way down, spk_mute_n=0 and dac_en=0, and the block is off.
- R9: A start request is acted on only when the block is off. A stop request is acted on only in the playing state. Requests in any other state, including during either ramp, have no effect.
- R10: A start request accepted in the off state sets dac_en=1 and spk_mute_n=1 and clears vol_code and amp_en in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Power-up request pulse |
| stop_req | input | 1 | Power-down request pulse |
| flash_cs_n | input | 1 | External flash chip-select, active low; gates the start of the up-ramp |
| vol_target | input | VOL_W | Volume loaded once mid-scale is reached |
| settle_cfg | input | SETTLE_W | Amplifier settle time in step ticks, captured while off |
| dac_code | output | CODE_W | DAC input code |
| dac_en | output | 1 | DAC enable |
| amp_en | output | 1 | Speaker amplifier enable |
| spk_mute_n | output | 1 | Speaker mute control, low mutes |
| vol_code | output | VOL_W | Volume setting |
| ready | output | 1 | Audio stream may drive the DAC |

## Verification
The hardest case to reach is a request that arrives while a ramp is in progress. The block accepts requests only at the two ends of its sequence, so a stray pulse in the middle of a ramp is easy never to provoke. The stimulus fires both start and stop pulses part-way through every up-ramp and a start pulse part-way through every down-ramp. It also fires a stop pulse while the block waits for the chip-select. It then confirms that each ramp still runs to its end point in unit steps and that no new sequence begins afterwards. The settle configuration is also changed while the amplifier is settling, so a value latched at the wrong time would show up as a wrong mute delay.

// File: rtl/pop_seq_pkg.sv
`timescale 1ns/1ps
package pop_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_CS,
    ST_RAMP_UP,
    ST_SET_VOL,
    ST_PA_SETTLE,
    ST_PLAYING,
    ST_RAMP_DOWN,
    ST_FINAL_OFF
  } seq_state_e;
endpackage

// File: rtl/pop_step_tick.sv
`timescale 1ns/1ps
// Step pacing: one tick every TICK_DIV cycles while run_i is held.
module pop_step_tick #(
  parameter int TICK_DIV = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i || tick_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  initial assert (TICK_DIV >= 2);

  // Two ticks never come back to back (R2 step spacing)
  p_tick_spaced_r2: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/pop_code_ramp.sv
`timescale 1ns/1ps
// Unit-step up/down counter for the DAC code, bounded by 0 and mid-scale.
module pop_code_ramp #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_i,
  input  logic              dn_i,
  output logic [CODE_W-1:0] code_o,
  output logic              up_last_o,
  output logic              dn_last_o
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

  assign up_last_o = (code_o == MID - ONE);
  assign dn_last_o = (code_o == ONE);

  always_ff @(posedge clk) begin
    if (rst)                        code_o <= '0;
    else if (up_i && code_o != MID) code_o <= code_o + ONE;
    else if (dn_i && code_o != '0)  code_o <= code_o - ONE;
  end

  p_code_cap_r2: assert property (@(posedge clk) disable iff (rst)
    code_o <= MID);

  p_unit_step_r2: assert property (@(posedge clk) disable iff (rst)
    (code_o != $past(code_o)) |->
      ((code_o == $past(code_o) + ONE) || (code_o == $past(code_o) - ONE)));
endmodule

// File: rtl/pop_settle_timer.sv
`timescale 1ns/1ps
// Counts step ticks after the amplifier is switched on; goal captured while off.
module pop_settle_timer #(
  parameter int SETTLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic [SETTLE_W-1:0] cfg_i,
  input  logic                run_i,
  input  logic                tick_i,
  output logic                done_o
);
  logic [SETTLE_W-1:0] goal_q;
  logic [SETTLE_W-1:0] cnt_q;
  logic [SETTLE_W:0]   goal_eff;

  assign goal_eff = (goal_q == '0) ? (SETTLE_W+1)'(1) : {1'b0, goal_q};
  assign done_o   = run_i && tick_i && (({1'b0, cnt_q} + 1'b1) >= goal_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      goal_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (load_i) goal_q <= cfg_i;
      if (!run_i)      cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  // Goal must not move while the timer runs (R5)
  p_goal_frozen_r5: assert property (@(posedge clk) disable iff (rst)
    run_i && $past(run_i) |-> $stable(goal_q));
endmodule

// File: rtl/pop_seq_fsm.sv
`timescale 1ns/1ps
// Sequence control: orders ramps, volume, mute and amplifier enable.
module pop_seq_fsm
  import pop_seq_pkg::*;
#(
  parameter int VOL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             flash_cs_n,
  input  logic [VOL_W-1:0] vol_target,
  input  logic             tick,
  input  logic             up_last,
  input  logic             dn_last,
  input  logic             settle_done,
  output logic             step_up,
  output logic             step_dn,
  output logic             tick_run,
  output logic             settle_run,
  output logic             settle_load,
  output logic             dac_en,
  output logic             amp_en,
  output logic             mute_n,
  output logic [VOL_W-1:0] vol_code,
  output logic             ready
);
  seq_state_e state_q;

  assign step_up     = (state_q == ST_RAMP_UP)   && tick;
  assign step_dn     = (state_q == ST_RAMP_DOWN) && tick;
  assign settle_run  = (state_q == ST_PA_SETTLE);
  assign settle_load = (state_q == ST_OFF);
  assign tick_run    = (state_q == ST_RAMP_UP) || (state_q == ST_PA_SETTLE) ||
                       (state_q == ST_RAMP_DOWN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      dac_en   <= 1'b1;
      amp_en   <= 1'b0;
      mute_n   <= 1'b1;
      vol_code <= '0;
      ready    <= 1'b0;
    end else begin
      case (state_q)
        ST_OFF: if (start_req) begin
          state_q  <= ST_WAIT_CS;
          dac_en   <= 1'b1;
          mute_n   <= 1'b1;
          amp_en   <= 1'b0;
          vol_code <= '0;
        end
        ST_WAIT_CS: if (!flash_cs_n) state_q <= ST_RAMP_UP;
        ST_RAMP_UP: if (tick && up_last) begin
          state_q  <= ST_SET_VOL;
          vol_code <= vol_target;
        end
        ST_SET_VOL: begin
          mute_n  <= 1'b0;
          state_q <= ST_PA_SETTLE;
        end
        ST_PA_SETTLE: begin
          amp_en <= 1'b1;
          if (settle_done) begin
            mute_n  <= 1'b1;
            ready   <= 1'b1;
            state_q <= ST_PLAYING;
          end
        end
        ST_PLAYING: if (stop_req) begin
          amp_en   <= 1'b0;
          vol_code <= '0;
          ready    <= 1'b0;
          state_q  <= ST_RAMP_DOWN;
        end
        ST_RAMP_DOWN: if (tick && dn_last) state_q <= ST_FINAL_OFF;
        ST_FINAL_OFF: begin
          mute_n  <= 1'b0;
          dac_en  <= 1'b0;
          state_q <= ST_OFF;
        end
        default: state_q <= ST_OFF;
      endcase
    end
  end

  p_cs_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RAMP_UP && $past(state_q) == ST_WAIT_CS) |-> !$past(flash_cs_n));

  p_ready_state_r6: assert property (@(posedge clk) disable iff (rst)
    ready |-> (state_q == ST_PLAYING));

  p_mute_hold_down_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RAMP_DOWN) |-> mute_n && !amp_en);
endmodule

// File: rtl/pop_seq_top.sv
`timescale 1ns/1ps
module pop_seq_top #(
  parameter int CODE_W   = 16,
  parameter int VOL_W    = 7,
  parameter int SETTLE_W = 16,
  parameter int TICK_DIV = 2000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_req,
  input  logic                stop_req,
  input  logic                flash_cs_n,
  input  logic [VOL_W-1:0]    vol_target,
  input  logic [SETTLE_W-1:0] settle_cfg,
  output logic [CODE_W-1:0]   dac_code,
  output logic                dac_en,
  output logic                amp_en,
  output logic                spk_mute_n,
  output logic [VOL_W-1:0]    vol_code,
  output logic                ready
);
  localparam logic [CODE_W-1:0] MID = {1'b1, {(CODE_W-1){1'b0}}};

  logic tick, tick_run, step_up, step_dn, up_last, dn_last;
  logic settle_run, settle_load, settle_done;

  pop_step_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .run_i(tick_run), .tick_o(tick));

  pop_code_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk(clk), .rst(rst), .up_i(step_up), .dn_i(step_dn),
    .code_o(dac_code), .up_last_o(up_last), .dn_last_o(dn_last));

  pop_settle_timer #(.SETTLE_W(SETTLE_W)) u_settle (
    .clk(clk), .rst(rst), .load_i(settle_load), .cfg_i(settle_cfg),
    .run_i(settle_run), .tick_i(tick), .done_o(settle_done));

  pop_seq_fsm #(.VOL_W(VOL_W)) u_fsm (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .flash_cs_n(flash_cs_n), .vol_target(vol_target), .tick(tick),
    .up_last(up_last), .dn_last(dn_last), .settle_done(settle_done),
    .step_up(step_up), .step_dn(step_dn), .tick_run(tick_run),
    .settle_run(settle_run), .settle_load(settle_load),
    .dac_en(dac_en), .amp_en(amp_en), .mute_n(spk_mute_n),
    .vol_code(vol_code), .ready(ready));

  p_amp_at_mid_r4: assert property (@(posedge clk) disable iff (rst)
    amp_en |-> (dac_code == MID));

  p_amp_after_mute_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(amp_en) |-> !spk_mute_n);

  p_ready_full_r6: assert property (@(posedge clk) disable iff (rst)
    ready |-> (amp_en && spk_mute_n && dac_code == MID));

  p_amp_off_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(amp_en) |-> (vol_code == '0));

  p_dac_off_at_zero_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_en) |-> (dac_code == '0 && !spk_mute_n));
endmodule

// File: tb/sim_pop_seq_top.sv
`timescale 1ns/1ps
module sim_pop_seq_top;
  localparam int CW  = 8;
  localparam int VW  = 7;
  localparam int SW  = 16;
  localparam int D   = 4;
  localparam int MID = 1 << (CW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0, stop_req = 1'b0, flash_cs_n = 1'b1;
  logic [VW-1:0] vol_target = '0;
  logic [SW-1:0] settle_cfg = '0;
  logic [CW-1:0] dac_code;
  logic dac_en, amp_en, spk_mute_n, ready;
  logic [VW-1:0] vol_code;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  pop_seq_top #(.CODE_W(CW), .VOL_W(VW), .SETTLE_W(SW), .TICK_DIV(D)) u0 (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .flash_cs_n(flash_cs_n), .vol_target(vol_target), .settle_cfg(settle_cfg),
    .dac_code(dac_code), .dac_en(dac_en), .amp_en(amp_en),
    .spk_mute_n(spk_mute_n), .vol_code(vol_code), .ready(ready));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_gap(input int s);
    return ((s == 0) ? 1 : s) * D - 1;
  endfunction

  // Continuous step monitor: unit steps (R2/R7), step spacing, ready invariant (R6)
  int prev_code = 0;
  int since = 0;
  always @(negedge clk) begin
    if (rst) begin
      prev_code = int'(dac_code);
      since = 0;
    end else begin
      since++;
      if (int'(dac_code) != prev_code) begin
        chk("R2/R7 unit step", (int'(dac_code) == prev_code + 1 || int'(dac_code) == prev_code - 1) ? 1 : 0, 1);
        if ((int'(dac_code) == prev_code + 1 && prev_code != 0) ||
            (int'(dac_code) == prev_code - 1 && prev_code != MID))
          chk("R2/R7 step spacing", since, D);
        since = 0;
        prev_code = int'(dac_code);
      end
      if (ready) chk("R6 ready implies playing outputs",
                     (amp_en && spk_mute_n && int'(dac_code) == MID) ? 1 : 0, 1);
    end
  end

  task automatic pulse_start();
    start_req = 1'b1; @(negedge clk); start_req = 1'b0;
  endtask

  task automatic pulse_stop();
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
  endtask

  task automatic run_cycle(input int vol, input int settle, input int cs_wait);
    int n;
    @(negedge clk);
    flash_cs_n = 1'b1;
    vol_target = VW'(vol);
    settle_cfg = SW'(settle);
    pulse_start();
    chk("R10 dac_en after start", int'(dac_en), 1);
    chk("R10 mute_n after start", int'(spk_mute_n), 1);
    chk("R10 amp_en after start", int'(amp_en), 0);
    pulse_stop();  // R9: ignored while waiting for chip-select
    repeat (cs_wait) @(negedge clk);
    chk("R3 code held while cs high", int'(dac_code), 0);
    chk("R9 stop ignored in wait", int'(dac_en), 1);
    flash_cs_n = 1'b0;
    repeat (10) @(negedge clk);
    start_req = 1'b1; stop_req = 1'b1;  // R9: both ignored mid-ramp
    @(negedge clk);
    start_req = 1'b0; stop_req = 1'b0;
    while (int'(dac_code) != MID) @(negedge clk);
    chk("R4 vol loaded at mid", int'(vol_code), vol);
    chk("R4 mute still high at mid", int'(spk_mute_n), 1);
    chk("R4 amp off at mid", int'(amp_en), 0);
    settle_cfg = SW'(settle + 7);  // R5: not off, must be ignored
    @(negedge clk);
    chk("R4 mute low after vol", int'(spk_mute_n), 0);
    chk("R4 amp still off", int'(amp_en), 0);
    @(negedge clk);
    chk("R4 amp on after mute", int'(amp_en), 1);
    chk("R6 ready low while settling", int'(ready), 0);
    n = 0;
    while (!spk_mute_n) begin @(negedge clk); n++; end
    chk("R5 settle gap", n, exp_gap(settle));
    chk("R6 ready with unmute", int'(ready), 1);
    pulse_start();  // R9: ignored while playing
    repeat (5) @(negedge clk);
    chk("R9 start ignored in play", int'(ready), 1);
    chk("R9 code held in play", int'(dac_code), MID);
    pulse_stop();
    chk("R7 amp off on stop", int'(amp_en), 0);
    chk("R7 vol cleared on stop", int'(vol_code), 0);
    chk("R6 ready drops on stop", int'(ready), 0);
    chk("R7 mute high on stop", int'(spk_mute_n), 1);
    repeat (8) @(negedge clk);
    pulse_start();  // R9: ignored mid down-ramp
    while (int'(dac_code) != 0) @(negedge clk);
    chk("R7 mute high at zero", int'(spk_mute_n), 1);
    chk("R7 dac still on at zero", int'(dac_en), 1);
    @(negedge clk);
    chk("R8 mute low at off", int'(spk_mute_n), 0);
    chk("R8 dac off", int'(dac_en), 0);
    repeat (20) @(negedge clk);
    chk("R9 no restart after ramp start pulse", int'(dac_en), 0);
    pulse_stop();  // R9: ignored when off
    repeat (5) @(negedge clk);
    chk("R9 stop ignored off code", int'(dac_code), 0);
    chk("R9 stop ignored off amp", int'(amp_en), 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset code", int'(dac_code), 0);
    chk("R1 reset dac_en", int'(dac_en), 1);
    chk("R1 reset amp_en", int'(amp_en), 0);
    chk("R1 reset mute_n", int'(spk_mute_n), 1);
    chk("R1 reset vol", int'(vol_code), 0);
    chk("R1 reset ready", int'(ready), 0);
    run_cycle(127, 0, 30);
    run_cycle(0, 1, 1);
    for (int i = 0; i < 5; i++)
      run_cycle(int'($urandom % 128), int'($urandom % 6), 1 + int'($urandom % 20));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule